// File: doc/BRIEF.md
# Key-Protected System Watchdog Timer

This block is a system watchdog with a small register file on an APB-style peripheral bus. It has zero wait states and no ready signal. Software programs a timeout period and a mode, then starts the timer. After that it must keep writing a restart key before the count runs out. If it fails to do so, the block drives a system reset pulse and an interrupt pulse. Each pulse has a programmed length, and each can be enabled on its own.

Each configuration register accepts a write only when the write carries that register's own key in its upper bits. The period register is also locked while the timer runs. The safe sequence to change the period is therefore: stop the timer with a keyed mode write, rewrite the period, then start it again.

The period is built from a reload field and a prescaler select. The reload field forms the upper part of a down-counter whose lower bits are loaded with all ones. A tick prescaler divides the clock. Clock source choice and pin routing live outside the block, which sees one clock.

Top module: `kwdt_top`

## Requirements
- R1: A write to the mode word (address 0x0) changes the mode only when bits [31:20] equal 0xABC; any other key leaves it unchanged. The mode fields are: bit 0 run, bit 1 reset-output enable, bit 2 interrupt enable, bits [4:3] reset length code, bits [6:5] interrupt length code.
- R2: A write to the period word (address 0x4) changes it only when bits [31:20] equal 0x248. Its fields are: bits [1:0] prescaler select s, and bits [RELOAD_W+1:2] reload value r. After reset, s is 3 and r is all ones.
- R3: While the run bit is set, every write to the period word is ignored, even with the right key, and the running timeout is not altered.
- R4: The first expiry occurs (({r, LOW_W ones}) + 1) * 2^(PRE_SHIFT*(s+1)) clock cycles after the write that sets the run bit. The count restarts from the same value after each expiry.
- R5: A write to the restart word (address 0x8) whose bits [19:4] equal 0x1999 reloads the count and the prescaler. The next expiry then comes one full period after that write. A restart with any other key has no effect on the timing.
- R6: On expiry with the reset enable set, wdt_rst_o goes high for 4 << code cycles (code 0..3 gives 4, 8, 16, 32), starting the cycle after the expiry edge.
- R7: On expiry with the interrupt enable set, wdt_irq_o goes high for max(4 << code, IRQ_MIN) cycles.
- R8: An output never pulses while its enable bit is clear. While the run bit is clear, neither output pulses.
- R9: Status (address 0xC, bit 0) becomes 1 at an expiry. It stays 1 until an accepted restart, or an accepted mode write that clears the run bit.
- R10: Reads return the fields in the positions above with all key bits as zero. The restart word reads as zero.
- R11: After reset, the mode reads 0, the period word reads with s = 3 and r all ones, the status reads 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the count source |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | ADDR_W | Byte address; word aligned, register index in bits [3:2] |
| pwdata | input | 32 | Write data including key fields |
| prdata | output | 32 | Read data, valid during a read access |
| wdt_rst_o | output | 1 | System reset pulse |
| wdt_irq_o | output | 1 | Interrupt pulse |

## Verification
The bench mostly sees faults in the down-counter or the prescaler as an expiry edge that comes early or late. It counts that edge exactly against the arithmetic period, so an error of one cycle is visible at the first expiry. A wrong register or a wrong key compare shows at once on the next readback, or as a change in period that the timing sweep catches within one period. Faults in the pulse generators show as a wrong high width on the first pulse. Faults in the status flag show on the read after an expiry, a restart or a disable.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
   localparam int DATA_W     = 32;
   localparam int SEL_W      = 2;
   localparam int CODE_W     = 2;
   localparam int MODE_W     = 7;
   localparam logic [11:0] MODE_KEY    = 12'hABC;
   localparam logic [11:0] PERIOD_KEY  = 12'h248;
   localparam logic [15:0] RESTART_KEY = 16'h1999;

   typedef enum logic [1:0] {
      IDX_MODE    = 2'd0,
      IDX_PERIOD  = 2'd1,
      IDX_RESTART = 2'd2,
      IDX_STATUS  = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic [CODE_W-1:0] irq_code;
      logic [CODE_W-1:0] rst_code;
      logic              irq_en;
      logic              rst_en;
      logic              run;
   } mode_t;
endpackage

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int RELOAD_W = 12,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [DATA_W-1:0]   pwdata,
   input  logic                expire_i,
   output logic [DATA_W-1:0]   prdata,
   output mode_t               mode_q,
   output logic [SEL_W-1:0]    presc_q,
   output logic [RELOAD_W-1:0] reload_q,
   output logic                load_o,
   output logic                timed_out_q
);
   localparam int PERIOD_BITS = RELOAD_W + SEL_W;

   initial begin
      assert (RELOAD_W >= 1 && RELOAD_W <= 18)
         else $error("kwdt_regs: RELOAD_W must be 1..18");
      assert (ADDR_W >= 4)
         else $error("kwdt_regs: ADDR_W must be at least 4");
   end

   logic        addr_ok;
   reg_idx_e    idx;
   logic        wr_acc;
   logic        rd_acc;
   logic [11:0] cfg_key;
   logic [15:0] rs_key;
   mode_t       new_mode;
   logic        mode_wr;
   logic        period_wr;
   logic        restart_wr;
   logic        flag_clr;

   assign addr_ok    = (paddr[1:0] == 2'b00) && ((paddr >> 4) == '0);
   assign idx        = reg_idx_e'(paddr[3:2]);
   assign wr_acc     = psel && penable && pwrite && addr_ok;
   assign rd_acc     = psel && !pwrite && addr_ok;
   assign cfg_key    = pwdata[31:20];
   assign rs_key     = pwdata[19:4];
   assign new_mode   = mode_t'(pwdata[MODE_W-1:0]);

   assign mode_wr    = wr_acc && (idx == IDX_MODE) && (cfg_key == MODE_KEY);
   assign period_wr  = wr_acc && (idx == IDX_PERIOD) && (cfg_key == PERIOD_KEY)
                       && !mode_q.run;
   assign restart_wr = wr_acc && (idx == IDX_RESTART) && (rs_key == RESTART_KEY);
   assign load_o     = (mode_wr && new_mode.run && !mode_q.run)
                       || (restart_wr && mode_q.run);
   assign flag_clr   = restart_wr || (mode_wr && !new_mode.run);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_wr) begin
         mode_q <= new_mode;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q  <= '1;
         reload_q <= '1;
      end else if (period_wr) begin
         presc_q  <= pwdata[SEL_W-1:0];
         reload_q <= pwdata[PERIOD_BITS-1:SEL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timed_out_q <= 1'b0;
      end else if (flag_clr) begin
         timed_out_q <= 1'b0;
      end else if (expire_i) begin
         timed_out_q <= 1'b1;
      end
   end

   always_comb begin
      prdata = '0;
      if (rd_acc) begin
         unique case (idx)
            IDX_MODE:    prdata = DATA_W'(mode_q);
            IDX_PERIOD:  prdata = DATA_W'({reload_q, presc_q});
            IDX_RESTART: prdata = '0;
            IDX_STATUS:  prdata = DATA_W'(timed_out_q);
            default:     prdata = '0;
         endcase
      end
   end

   AST_MODE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && idx == IDX_MODE && cfg_key != MODE_KEY) |=> $stable(mode_q)); // R1
   AST_PERIOD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && idx == IDX_PERIOD && cfg_key != PERIOD_KEY)
      |=> ($stable(presc_q) && $stable(reload_q))); // R2
   AST_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && idx == IDX_PERIOD && mode_q.run)
      |=> ($stable(presc_q) && $stable(reload_q))); // R3
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && idx == IDX_RESTART && rs_key == RESTART_KEY) |=> !timed_out_q); // R9
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !psel) |=> timed_out_q); // R9
   AST_READ_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |-> (prdata[31:20] == '0)); // R10
endmodule

// File: rtl/kwdt_core.sv
`timescale 1ns/1ps
module kwdt_core
   import kwdt_pkg::*;
#(
   parameter int RELOAD_W  = 12,
   parameter int LOW_W     = 12,
   parameter int PRE_SHIFT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_i,
   input  logic                load_i,
   input  logic [SEL_W-1:0]    presc_i,
   input  logic [RELOAD_W-1:0] reload_i,
   output logic                expire_o
);
   localparam int CNT_W = RELOAD_W + LOW_W;
   localparam int NDIV  = 2 ** SEL_W;
   localparam int PRE_W = PRE_SHIFT * NDIV;

   initial begin
      assert (LOW_W >= 1) else $error("kwdt_core: LOW_W must be at least 1");
      assert (PRE_SHIFT >= 1 && PRE_SHIFT <= 6)
         else $error("kwdt_core: PRE_SHIFT must be 1..6");
   end

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic [NDIV-1:0]  tick_vec;
   logic             tick;

   for (genvar i = 0; i < NDIV; i++) begin : g_div
      assign tick_vec[i] = &pre_q[PRE_SHIFT*(i+1)-1:0];
   end

   assign tick     = tick_vec[presc_i];
   assign load_val = {reload_i, {LOW_W{1'b1}}};
   assign expire_o = run_i && !load_i && tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         pre_q <= '0;
         cnt_q <= load_val;
      end else if (run_i) begin
         pre_q <= pre_q + 1'b1;
         if (tick) begin
            cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
         end
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
   AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val) && pre_q == '0)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> ($stable(cnt_q) && $stable(pre_q))); // R8
endmodule

// File: rtl/kwdt_pulse.sv
`timescale 1ns/1ps
module kwdt_pulse
   import kwdt_pkg::*;
#(
   parameter int BASE_LEN = 4,
   parameter int MIN_LEN  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pulse_o
);
   localparam int MAX_BASE = BASE_LEN << ((2 ** CODE_W) - 1);
   localparam int LEN_MAX  = (MAX_BASE > MIN_LEN) ? MAX_BASE : MIN_LEN;
   localparam int MIN_EFF  = (BASE_LEN > MIN_LEN) ? BASE_LEN : MIN_LEN;
   localparam int LW       = $clog2(LEN_MAX + 1);
   localparam int HW       = LW + 1;

   initial begin
      assert (BASE_LEN >= 1) else $error("kwdt_pulse: BASE_LEN must be at least 1");
   end

   logic [LW-1:0] len_raw;
   logic [LW-1:0] len;
   logic [LW-1:0] cnt_q;
   logic [HW-1:0] hi_q;

   assign len_raw = LW'(BASE_LEN) << code_i;

   if (MIN_LEN > BASE_LEN) begin : g_stretch
      assign len = (len_raw < LW'(MIN_LEN)) ? LW'(MIN_LEN) : len_raw;
   end else begin : g_plain
      assign len = len_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (fire_i) begin
         cnt_q <= len;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pulse_o = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
      end else if (!pulse_o) begin
         hi_q <= '0;
      end else if (hi_q != '1) begin
         hi_q <= hi_q + 1'b1;
      end
   end

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LW'(LEN_MAX)); // R6
   AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_o) |-> (hi_q >= HW'(MIN_EFF))); // R7
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int RELOAD_W  = 12,
   parameter int LOW_W     = 12,
   parameter int PRE_SHIFT = 3,
   parameter int BASE_LEN  = 4,
   parameter int IRQ_MIN   = 8,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              wdt_rst_o,
   output logic              wdt_irq_o
);
   localparam int NOUT = 2;

   mode_t               mode_q;
   logic [SEL_W-1:0]    presc_q;
   logic [RELOAD_W-1:0] reload_q;
   logic                load;
   logic                timed_out;
   logic                expire;
   logic [NOUT-1:0]     out_en;
   logic [CODE_W-1:0]   out_code [NOUT];
   logic [NOUT-1:0]     out_pulse;

   kwdt_regs #(.RELOAD_W(RELOAD_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .expire_i(expire),
      .prdata(prdata), .mode_q(mode_q), .presc_q(presc_q),
      .reload_q(reload_q), .load_o(load), .timed_out_q(timed_out)
   );

   kwdt_core #(.RELOAD_W(RELOAD_W), .LOW_W(LOW_W), .PRE_SHIFT(PRE_SHIFT)) core_i (
      .clk(clk), .rst_n(rst_n), .run_i(mode_q.run), .load_i(load),
      .presc_i(presc_q), .reload_i(reload_q), .expire_o(expire)
   );

   assign out_en      = {mode_q.irq_en, mode_q.rst_en};
   assign out_code[0] = mode_q.rst_code;
   assign out_code[1] = mode_q.irq_code;

   for (genvar g = 0; g < NOUT; g++) begin : g_out
      kwdt_pulse #(.BASE_LEN(BASE_LEN), .MIN_LEN((g == 1) ? IRQ_MIN : 0)) pulse_i (
         .clk(clk), .rst_n(rst_n), .fire_i(expire && out_en[g]),
         .code_i(out_code[g]), .pulse_o(out_pulse[g])
      );
      AST_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_pulse[g]) |-> $past(out_en[g] && mode_q.run)); // R8
   end

   assign wdt_rst_o = out_pulse[0];
   assign wdt_irq_o = out_pulse[1];

   AST_STATUS_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst_o) |-> timed_out); // R9
endmodule

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;
   localparam int RW = 12;
   localparam int LW = 2;
   localparam int PS = 1;
   localparam int IMIN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [3:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        wdt_rst_o;
   logic        wdt_irq_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   kwdt_top #(.RELOAD_W(RW), .LOW_W(LW), .PRE_SHIFT(PS), .BASE_LEN(4),
              .IRQ_MIN(IMIN), .ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
   );

   initial forever #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mode_w(input logic [11:0] key, input int ic,
                                          input int rc, input bit irq, input bit rst,
                                          input bit run);
      return {key, 20'd0} | 32'(ic << 5) | 32'(rc << 3) | 32'({irq, rst, run});
   endfunction

   function automatic logic [31:0] period_w(input logic [11:0] key, input int r, input int s);
      return {key, 20'd0} | 32'(r << 2) | 32'(s);
   endfunction

   function automatic int period_cyc(input int r, input int s);
      return ((r << LW) + (1 << LW)) << (PS * (s + 1));
   endfunction

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(posedge clk);
      #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1;
      d = prdata;
      @(posedge clk);
      #1;
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic wait_rst(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(posedge clk);
         #1;
         if (wdt_rst_o) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic stop_wdt();
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 0, 0));
      idle(40);
   endtask

   initial begin
      logic [31:0] rd;
      bit seen;
      int t0;
      int w;
      int wi;
      logic [11:0] bad_keys [4];
      bad_keys[0] = 12'hABB; bad_keys[1] = 12'h000;
      bad_keys[2] = 12'h248; bad_keys[3] = 12'hFFF;

      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R11 and R10: reset values, keys read as zero
      chk("R11 rst_o after reset", wdt_rst_o, 0);
      chk("R11 irq_o after reset", wdt_irq_o, 0);
      bus_rd(4'h0, rd); chk("R11 mode reset", rd, 0);
      bus_rd(4'h4, rd); chk("R11 period reset", rd, 32'h3FFF);
      bus_rd(4'hC, rd); chk("R11 status reset", rd, 0);
      bus_rd(4'h8, rd); chk("R10 restart reads zero", rd, 0);

      // R1: mode key
      for (int k = 0; k < 4; k++) begin
         bus_wr(4'h0, {bad_keys[k], 20'd0} | 32'h7E);
         bus_rd(4'h0, rd); chk("R1 wrong mode key ignored", rd, 0);
      end
      bus_wr(4'h0, mode_w(12'hABC, 3, 2, 1, 1, 0));
      bus_rd(4'h0, rd); chk("R1 keyed mode write", rd, 32'h76);
      chk("R10 mode key bits zero", rd[31:20], 0);
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 0, 0));

      // R2: period key
      bad_keys[2] = 12'hABC;
      for (int k = 0; k < 4; k++) begin
         bus_wr(4'h4, {bad_keys[k], 20'd0} | 32'h15);
         bus_rd(4'h4, rd); chk("R2 wrong period key ignored", rd, 32'h3FFF);
      end
      bus_wr(4'h4, period_w(12'h248, 5, 2));
      bus_rd(4'h4, rd); chk("R2 keyed period write", rd, 32'h16);

      // R4 and R6: timing sweep over prescaler and small reloads
      for (int s = 0; s < 4; s++) begin
         for (int r = 0; r < 4; r++) begin
            bus_wr(4'h4, period_w(12'h248, r, s));
            bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 1, 1));
            t0 = cyc;
            wait_rst(2000, seen);
            chk($sformatf("R4 expiry delay s=%0d r=%0d", s, r),
                seen ? (cyc - t0) : -1, period_cyc(r, s));
            w = 1;
            for (int i = 0; i < 64; i++) begin
               @(posedge clk); #1;
               if (!wdt_rst_o) break;
               w++;
            end
            chk("R6 reset width code 0", w, 4);
            if (s == 3 && r == 3) begin
               bus_rd(4'hC, rd); chk("R9 status set on expiry", rd, 1);
            end
            stop_wdt();
         end
      end
      bus_rd(4'hC, rd); chk("R9 status cleared by disable", rd, 0);

      // R6 and R7: pulse widths per code, interrupt stretched to minimum
      bus_wr(4'h4, period_w(12'h248, 3, 3));
      for (int c = 0; c < 4; c++) begin
         bus_wr(4'h0, mode_w(12'hABC, c, c, 1, 1, 1));
         wait_rst(400, seen);
         chk("R6 reset pulse seen", seen, 1);
         w = 1;
         wi = wdt_irq_o ? 1 : 0;
         for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            if (wdt_rst_o) w++;
            if (wdt_irq_o) wi++;
         end
         chk($sformatf("R6 reset width code %0d", c), w, 4 << c);
         chk($sformatf("R7 irq width code %0d", c), wi,
             ((4 << c) < IMIN) ? IMIN : (4 << c));
         stop_wdt();
      end

      // R8: output enables and run bit
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 1, 0, 1));
      w = 0; wi = 0;
      for (int i = 0; i < 300; i++) begin
         @(posedge clk); #1;
         if (wdt_rst_o) w++;
         if (wdt_irq_o) wi++;
      end
      chk("R8 reset stays low when disabled", w, 0);
      chk("R8 irq pulses when enabled", wi, IMIN);
      stop_wdt();
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 1, 1, 0));
      w = 0;
      for (int i = 0; i < 600; i++) begin
         @(posedge clk); #1;
         if (wdt_rst_o || wdt_irq_o) w++;
      end
      chk("R8 no pulse while not running", w, 0);
      stop_wdt();

      // R5: restart with good and bad key
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 1, 1));
      idle(100);
      bus_wr(4'h8, {12'd0, 16'h1999, 4'd0});
      t0 = cyc;
      wait_rst(600, seen);
      chk("R5 good restart reloads", seen ? (cyc - t0) : -1, period_cyc(3, 3));
      bus_rd(4'hC, rd); chk("R9 status after expiry", rd, 1);
      bus_wr(4'h8, {12'd0, 16'h1999, 4'd0});
      bus_rd(4'hC, rd); chk("R9 status cleared by restart", rd, 0);
      stop_wdt();
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 1, 1));
      t0 = cyc;
      idle(100);
      bus_wr(4'h8, {12'd0, 16'h1998, 4'd0});
      wait_rst(600, seen);
      chk("R5 bad restart ignored", seen ? (cyc - t0) : -1, period_cyc(3, 3));
      stop_wdt();

      // R3: period locked while running
      bus_wr(4'h0, mode_w(12'hABC, 0, 0, 0, 1, 1));
      t0 = cyc;
      idle(50);
      bus_wr(4'h4, period_w(12'h248, 0, 0));
      bus_rd(4'h4, rd); chk("R3 period locked while running", rd, 32'hF);
      wait_rst(600, seen);
      chk("R3 running timeout unaltered", seen ? (cyc - t0) : -1, period_cyc(3, 3));
      stop_wdt();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule